// File: doc/BRIEF.md
# Byte-Accessed Up-Counting Timer

This block is a 16-bit up-counter that an 8-bit host reaches one byte at a time through a two-bit address. The live count appears as a high byte and a low byte. A separate 16-bit reload value sets the terminal count. While the timer is enabled, the counter steps by one every clock. When the count equals the reload value, the counter returns to one and a wrap flag pulses.

The host can read a consistent 16-bit count while the counter runs. Reading the high byte also captures the low byte into a holding register, and a later low-byte read returns the captured byte. The host can also write either count byte while the counter runs, and counting carries on from the new value. Reload writes made while the timer runs are held in a shadow copy. They move into the active compare value only at the next wrap, so the compare never sees half of an update.

A small state machine governs the block. In STOP, counting is halted and reload writes reach the active value directly. In RUN, the counter is counting and no reload update is waiting. In PEND, the counter is counting and a staged reload update is waiting. The transitions are as follows. START goes from STOP to RUN when `en` is seen high. STAGE goes from RUN to PEND on a reload write. COMMIT goes from PEND to RUN on a wrap with no reload write in that cycle. HALT goes from RUN or PEND to STOP when `en` is seen low. HALT from PEND also commits the staged value.

Top module: `bytetimer`

## Requirements
- R1: After reset, both count bytes, both reload bytes, `rdata` and `wrap` are zero, and the state is STOP.
- R2: `en` is sampled at each clock, and the first increment happens one clock after `en` is first sampled high. Keeping `en` high for m consecutive cycles from STOP adds exactly m to the count, with carry from the low byte into the high byte.
- R3: While counting, a count equal to the active reload value becomes 0x0001 at the next clock. `wrap` is high for the cycle after each such match, and there is one high cycle per match. A count above the reload value passes through 0xFFFF to 0x0000 with no flag.
- R4: While the timer is disabled, the count keeps its value: it is neither cleared nor changed except by host writes.
- R5: A write to address 0 (count high) or address 1 (count low) replaces that byte at the next clock, whether the timer is enabled or disabled. In a counting cycle, the other byte takes the value the increment gives it, and counting continues from the result.
- R6: A read of address 0 returns the current high count byte on `rdata` one clock later. If the timer is enabled, the same read also copies the low count byte into the holding register.
- R7: A read of address 1 returns the holding register while the timer is enabled, and the live low count byte while it is disabled, one clock later.
- R8: While the timer is disabled, a write to address 2 (reload high) or address 3 (reload low) sets that byte of the active reload value at the next clock.
- R9: While the timer is enabled, reload writes go only to the shadow copy. The active reload value takes the whole shadow at the next wrap, or when the timer is disabled, whichever comes first.
- R10: Reads of addresses 2 and 3 return the most recently written reload high and low bytes one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Timer enable, sampled each clock |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | 0 count high, 1 count low, 2 reload high, 3 reload low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wrap | output | 1 | One cycle per terminal-count match |

## Verification
The bench drives inputs on the falling edge and samples on the falling edge after the rising edge of interest.

- **Read data:** `rdata` is due one edge after the read strobe.
- **Byte writes:** a write lands on the next edge.
- **Enable:** `en` takes effect one edge late, so m enabled cycles give exactly m increments. The last increment falls on the edge where `en` is seen low.
- **Wrap:** `wrap` rises on the same edge that returns the count to one.

Expected counts and wrap totals are worked out by formula from the reload value, the number of enabled cycles and the edge index of each write or read. Final counts are read back through the byte registers while the timer is disabled.

// File: rtl/bytetimer_pkg.sv
package bytetimer_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } bt_state_e;

    localparam logic [1:0] ADDR_CNT_HI = 2'd0;
    localparam logic [1:0] ADDR_CNT_LO = 2'd1;
    localparam logic [1:0] ADDR_RLD_HI = 2'd2;
    localparam logic [1:0] ADDR_RLD_LO = 2'd3;

endpackage

// File: rtl/bytetimer_ctrl.sv
module bytetimer_ctrl
    import bytetimer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rld_wr,
    input  logic hit,
    output logic running,
    output logic load_act
);

    bt_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nx;
    end

    // transitions: START, STAGE, COMMIT, HALT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOP: if (en) state_nx = ST_RUN;
            ST_RUN: begin
                if (!en)         state_nx = ST_STOP;
                else if (rld_wr) state_nx = ST_PEND;
            end
            ST_PEND: begin
                if (!en)                 state_nx = ST_STOP;
                else if (hit && !rld_wr) state_nx = ST_RUN;
            end
            default: state_nx = ST_STOP;
        endcase
    end

    // outputs
    always_comb begin
        running  = 1'b0;
        load_act = 1'b0;
        unique case (state)
            ST_STOP: ;
            ST_RUN:  running = 1'b1;
            ST_PEND: begin
                running  = 1'b1;
                load_act = hit || !en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bytetimer_reload.sv
module bytetimer_reload #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              running,
    input  logic              load_act,
    output logic [CNT_W-1:0]  shd,
    output logic [CNT_W-1:0]  act
);

    logic [CNT_W-1:0] shd_nx;

    always_comb begin
        shd_nx = shd;
        if (wr_hi) shd_nx[CNT_W-1:BYTE_W] = wdata;
        if (wr_lo) shd_nx[BYTE_W-1:0]     = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd <= '0;
            act <= '0;
        end else begin
            shd <= shd_nx;
            // stopped: writes go straight through; running: only at commit
            if (!running || load_act) act <= shd_nx;
        end
    end

endmodule

// File: rtl/bytetimer_counter.sv
module bytetimer_counter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  reload,
    output logic [CNT_W-1:0]  cnt,
    output logic              hit,
    output logic              wrap
);

    logic [CNT_W-1:0] cnt_nx;

    assign hit = (cnt == reload);

    always_comb begin
        cnt_nx = cnt;
        if (running) cnt_nx = hit ? CNT_W'(1) : cnt + CNT_W'(1);
        // a host byte write overrides only its own byte
        if (wr_hi) cnt_nx[CNT_W-1:BYTE_W] = wdata;
        if (wr_lo) cnt_nx[BYTE_W-1:0]     = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else begin
            cnt  <= cnt_nx;
            wrap <= running && hit;
        end
    end

endmodule

// File: rtl/bytetimer_readout.sv
module bytetimer_readout
    import bytetimer_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic              running,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  rld,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            hold  <= '0;
        end else if (rd_en) begin
            unique case (addr)
                ADDR_CNT_HI: begin
                    rdata <= cnt[CNT_W-1:BYTE_W];
                    if (running) hold <= cnt[BYTE_W-1:0];
                end
                ADDR_CNT_LO: rdata <= running ? hold : cnt[BYTE_W-1:0];
                ADDR_RLD_HI: rdata <= rld[CNT_W-1:BYTE_W];
                ADDR_RLD_LO: rdata <= rld[BYTE_W-1:0];
                default:     rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/bytetimer.sv
module bytetimer
    import bytetimer_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              wrap
);

    logic             running, load_act, hit;
    logic             wr_cnt_hi, wr_cnt_lo, wr_rld_hi, wr_rld_lo;
    logic [CNT_W-1:0] cnt, rld_act, rld_shd;

    assign wr_cnt_hi = wr_en && (addr == ADDR_CNT_HI);
    assign wr_cnt_lo = wr_en && (addr == ADDR_CNT_LO);
    assign wr_rld_hi = wr_en && (addr == ADDR_RLD_HI);
    assign wr_rld_lo = wr_en && (addr == ADDR_RLD_LO);

    bytetimer_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rld_wr   (wr_rld_hi || wr_rld_lo),
        .hit      (hit),
        .running  (running),
        .load_act (load_act)
    );

    bytetimer_reload #(.BYTE_W(BYTE_W)) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hi    (wr_rld_hi),
        .wr_lo    (wr_rld_lo),
        .wdata    (wdata),
        .running  (running),
        .load_act (load_act),
        .shd      (rld_shd),
        .act      (rld_act)
    );

    bytetimer_counter #(.BYTE_W(BYTE_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .wr_hi   (wr_cnt_hi),
        .wr_lo   (wr_cnt_lo),
        .wdata   (wdata),
        .reload  (rld_act),
        .cnt     (cnt),
        .hit     (hit),
        .wrap    (wrap)
    );

    bytetimer_readout #(.BYTE_W(BYTE_W)) u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .running (running),
        .cnt     (cnt),
        .rld     (rld_shd),
        .rdata   (rdata)
    );

endmodule

// File: rtl/bytetimer_chk.sv
module bytetimer_chk #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [BYTE_W-1:0] wdata,
    input logic [BYTE_W-1:0] rdata,
    input logic              wrap,
    input logic              running,
    input logic              hit,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  rld_act,
    input logic [CNT_W-1:0]  rld_shd
);

    logic cnt_wr;
    assign cnt_wr = wr_en && !addr[1];

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        running && (cnt != rld_act) && !cnt_wr
        |=> cnt == ($past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

    a_r3_wrap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        running && (cnt == rld_act) && !cnt_wr
        |=> (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) && wrap);

    a_r3_wrap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> $past(running) && $past(hit));

    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !cnt_wr |=> $stable(cnt));

    a_r5_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == 2'd0) |=> cnt[CNT_W-1:BYTE_W] == $past(wdata));

    a_r7_low_live: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == 2'd1) && !running |=> rdata == $past(cnt[BYTE_W-1:0]));

    a_r9_staged: assert property (@(posedge clk) disable iff (!rst_n)
        running && en && !hit && wr_en && addr[1] |=> $stable(rld_act));

    a_r10_rld_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == 2'd3) |=> rdata == $past(rld_shd[BYTE_W-1:0]));

endmodule

bind bytetimer bytetimer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .wrap    (wrap),
    .running (running),
    .hit     (hit),
    .cnt     (cnt),
    .rld_act (rld_act),
    .rld_shd (rld_shd)
);

// File: tb/bytetimer_bench.sv
module bytetimer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wrap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bytetimer u_bytetimer (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wrap(wrap)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] h, l;
        rd(2'd0, h);
        rd(2'd1, l);
        v = {h, l};
    endtask

    task automatic setup(input int c, input int r);
        wr(2'd0, c[15:8]); wr(2'd1, c[7:0]);
        wr(2'd2, r[15:8]); wr(2'd3, r[7:0]);
    endtask

    // m enabled cycles; op k: 1 write, 2 read, landing on edge index j
    task automatic run(input int m,
                       input int j1, input int k1, input logic [1:0] a1, input logic [7:0] d1,
                       input int j2, input int k2, input logic [1:0] a2, input logic [7:0] d2,
                       output logic [7:0] r1, output logic [7:0] r2, output int wraps);
        wraps = 0; r1 = 8'd0; r2 = 8'd0;
        for (int c = 1; c <= m + 3; c++) begin
            en = (c <= m); wr_en = 1'b0; rd_en = 1'b0;
            if (c == j1) begin addr = a1; wdata = d1; wr_en = (k1 == 1); rd_en = (k1 == 2); end
            if (c == j2) begin addr = a2; wdata = d2; wr_en = (k2 == 1); rd_en = (k2 == 2); end
            @(posedge clk); @(negedge clk);
            if (wrap) wraps++;
            if (c == j1 && k1 == 2) r1 = rdata;
            if (c == j2 && k2 == 2) r2 = rdata;
        end
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        logic [7:0] b, r1, r2;
        int v, w, exp, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 wrap", wrap, 0);
        rd(2'd0, b); chk("R1 cnt hi", b, 0);
        rd(2'd1, b); chk("R1 cnt lo", b, 0);
        rd(2'd2, b); chk("R1 rld hi", b, 0);
        rd(2'd3, b); chk("R1 rld lo", b, 0);

        // R2 increment count with low-byte carry
        for (int m = 1; m <= 30; m++) begin
            setup(16'h00FA, 16'hFFFF);
            run(m, 0, 0, 2'd0, 8'd0, 0, 0, 2'd0, 8'd0, r1, r2, w);
            rd_cnt(v);
            chk("R2 count", v, 16'h00FA + m);
            chk("R2 no wrap", w, 0);
        end

        // R3 and R8: sweep of reload value and run length
        for (int l = 1; l <= 6; l++) begin
            for (int m = 1; m <= 20; m++) begin
                setup(0, l);
                run(m, 0, 0, 2'd0, 8'd0, 0, 0, 2'd0, 8'd0, r1, r2, w);
                rd_cnt(v);
                chk("R3 count after wraps", v, ((m - 1) % l) + 1);
                chk("R3 wrap cycles", w, (m - 1) / l);
            end
        end

        // R3 pass through 0xFFFF with no flag, then match
        setup(16'hFFFE, 5);
        run(10, 0, 0, 2'd0, 8'd0, 0, 0, 2'd0, 8'd0, r1, r2, w);
        rd_cnt(v);
        chk("R3 rollover count", v, 3);
        chk("R3 rollover wraps", w, 1);

        // R4 retained while disabled
        repeat (10) @(negedge clk);
        rd_cnt(w);
        chk("R4 retained", w, v);

        // R5 low write while counting, carry into high
        setup(0, 16'hFFFF);
        run(10, 5, 1, 2'd1, 8'hFE, 0, 0, 2'd0, 8'd0, r1, r2, w);
        base = ((5 - 1) & 16'hFF00) | 8'hFE;
        exp  = (base + (10 + 1 - 5)) & 16'hFFFF;
        rd_cnt(v);
        chk("R5 low write running", v, exp);

        // R5 high write while counting
        setup(0, 16'hFFFF);
        run(8, 4, 1, 2'd0, 8'h12, 0, 0, 2'd0, 8'd0, r1, r2, w);
        base = 16'h1200 | ((4 - 1) & 8'hFF);
        exp  = (base + (8 + 1 - 4)) & 16'hFFFF;
        rd_cnt(v);
        chk("R5 high write running", v, exp);

        // R5 writes while disabled
        wr(2'd0, 8'hAB); wr(2'd1, 8'hCD);
        rd_cnt(v);
        chk("R5 disabled writes", v, 16'hABCD);

        // R6 and R7 coherent snapshot while running
        setup(16'h00F8, 16'hFFFF);
        run(20, 5, 2, 2'd0, 8'd0, 15, 2, 2'd1, 8'd0, r1, r2, w);
        chk("R6 high read running", r1, ((16'h00F8 + 5 - 2) >> 8) & 8'hFF);
        chk("R7 low read returns hold", r2, (16'h00F8 + 5 - 2) & 8'hFF);
        rd(2'd1, b);
        chk("R7 low read disabled live", b, (16'h00F8 + 20) & 8'hFF);
        rd(2'd0, b);
        chk("R6 high read disabled", b, ((16'h00F8 + 20) >> 8) & 8'hFF);

        // R9 staged reload, committed at next wrap
        setup(0, 4);
        run(12, 3, 1, 2'd3, 8'd2, 0, 0, 2'd0, 8'd0, r1, r2, w);
        rd_cnt(v);
        chk("R9 staged count", v, 2);
        chk("R9 staged wraps", w, 4);

        // R10 reload read back
        rd(2'd3, b); chk("R10 rld lo", b, 2);
        rd(2'd2, b); chk("R10 rld hi", b, 0);
        wr(2'd2, 8'h12); wr(2'd3, 8'h34);
        rd(2'd2, b); chk("R10 rld hi written", b, 8'h12);
        rd(2'd3, b); chk("R10 rld lo written", b, 8'h34);

        // R8 disabled reload write acts on next run
        setup(0, 3);
        run(7, 0, 0, 2'd0, 8'd0, 0, 0, 2'd0, 8'd0, r1, r2, w);
        rd_cnt(v);
        chk("R8 disabled reload count", v, ((7 - 1) % 3) + 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule